// File: doc/BRIEF.md
# GPIO Input Synchronizer and Edge Detector

This block takes a vector of asynchronous general-purpose input pins into the system clock domain. It turns chosen transitions on each pin into interrupt event pulses that last one clock. Each pin carries two independent select bits, one for rising transitions and one for falling transitions. Setting both gives detection on any edge. Clearing both silences the pin.

A chain of synchronizer flops feeds a history register that holds the synchronized level from one clock earlier. The block compares the synchronized level with that history, qualifies the result by the select bits, and registers it onto the event outputs. The synchronized level and the history are also brought out so that a register bank can show software the pin state. Latching of interrupt status, pad direction and bus access belong to neighbouring blocks.

After reset the block ignores every comparison until the history holds real samples. A pin that is already high when reset is released therefore never produces a false edge.

Top module: `gpio_edge_detect`

## Requirements
- R1: Each pin passes through two synchronizer flops. A level applied to `pin_in` appears on `pin_level` after the second rising clock edge, and not after the first.
- R2: `pin_prev` equals the value `pin_level` held one clock earlier.
- R3: With `rise_en[i]`=1, a 0-to-1 change on pin i raises `evt[i]` for one clock. The pulse follows the third rising edge after the change is applied.
- R4: With `fall_en[i]`=1, a 1-to-0 change on pin i raises `evt[i]` for one clock, with the same latency as R3.
- R5: With both select bits set, every change on pin i in either direction produces one pulse.
- R6: With both select bits clear, pin i never produces an event.
- R7: `evt[i]` is high only in the clock after a qualified change of pin i. Pins that did not change, or whose change was not selected, stay 0.
- R8: A synchronous active-high `rst` clears `pin_level`, `pin_prev` and `evt` to 0 on the next rising edge.
- R9: For the first three rising edges after reset is released, no event is produced. A pin held high through reset release creates no event.
- R10: A pulse on a pin that starts and ends between two rising clock edges is never seen: no event is produced and `pin_level` is unchanged.
- R11: The pin count is the parameter `PINS`, default 32. All vectors are `PINS` bits wide, and bit i of each vector belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | PINS | Asynchronous pin inputs |
| rise_en | input | PINS | Per-pin rising-edge select |
| fall_en | input | PINS | Per-pin falling-edge select |
| pin_level | output | PINS | Synchronized pin level |
| pin_prev | output | PINS | Synchronized level from one clock earlier |
| evt | output | PINS | One-clock edge event pulses |

## Verification
The assertions check on every cycle that:
- the synchronized level lags the pin by exactly two clocks;
- the history lags the level by one clock;
- events stay silent while the block is not armed;
- an event never appears without a change between level and history;
- an event never appears on a pin whose select bits were both clear;
- reset clears all three outputs.

Only the bench's scenarios can show the exact pulse latency and the direction selection pin by pin. They also show that back-to-back toggles give one pulse per edge, that a pin high through reset stays quiet, and that a glitch shorter than a clock is lost.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // Default geometry
    localparam int unsigned DEF_PINS  = 32;
    localparam int unsigned SYNC_DEPTH = 2;

    // Edge selection carried per pin: bit0 = rising, bit1 = falling
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    // Current and previous synchronized sample of one pin
    typedef struct packed {
        logic cur;
        logic old;
    } pin_pair_t;

    // Width of a counter that must reach n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Decide whether one pin's sample pair is a selected transition
    function automatic logic pin_hit(input pin_pair_t pr, input edge_sel_e sel);
        logic rose;
        logic fell;
        rose = pr.cur & ~pr.old;
        fell = ~pr.cur & pr.old;
        case (sel)
            EDGE_RISE: return rose;
            EDGE_FALL: return fell;
            EDGE_ANY:  return rose | fell;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS   = DEF_PINS,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] din,
    output logic [PINS-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][PINS-1:0] stage_q;

    // Repeated flop stages; stage 0 samples the raw pins
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[k] <= '0;
                else     stage_q[k] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[k] <= '0;
                else     stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign dout = stage_q[LAST];

    // R8: one edge of reset leaves the output cleared
    p_sync_clear_r8: assert property (@(posedge clk) $past(rst) |-> dout == '0);

endmodule

// File: rtl/gpio_sample_hist.sv
module gpio_sample_hist
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS   = DEF_PINS,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] cur,
    output logic [PINS-1:0] prev,
    output logic            armed
);

    // Edges after reset before level and history both hold real samples
    localparam int unsigned ARM_COUNT = STAGES + 1;
    localparam int unsigned CW        = cnt_bits(ARM_COUNT);
    localparam logic [CW-1:0] ARM_VAL = CW'(ARM_COUNT);

    logic [PINS-1:0] prev_q;
    logic [CW-1:0]   warm_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    // Saturating warm-up counter
    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != ARM_VAL) warm_q <= warm_q + 1'b1;
    end

    assign prev  = prev_q;
    assign armed = (warm_q == ARM_VAL);

    // R2: history lags the synchronized level by one clock
    p_prev_lag_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> prev == $past(cur));

    // R8: history cleared by reset
    p_prev_clear_r8: assert property (@(posedge clk) $past(rst) |-> prev == '0);

endmodule

// File: rtl/gpio_edge_match.sv
module gpio_edge_match
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS = DEF_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic [PINS-1:0] cur,
    input  logic [PINS-1:0] prev,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    output logic [PINS-1:0] evt
);

    logic [PINS-1:0] hit_d;
    logic [PINS-1:0] evt_q;

    // Per-pin comparison of the sample pair under its edge selection
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_pair_t pr;
        edge_sel_e sel;
        assign pr    = '{cur: cur[i], old: prev[i]};
        assign sel   = edge_sel_e'({fall_en[i], rise_en[i]});
        assign hit_d[i] = pin_hit(pr, sel);
    end

    // Registered event, held low until the history is real
    always_ff @(posedge clk) begin
        if (rst)        evt_q <= '0;
        else if (armed) evt_q <= hit_d;
        else            evt_q <= '0;
    end

    assign evt = evt_q;

    // R6: no event on a pin whose selects were both clear
    p_unselected_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        armed |-> (evt & ~$past(rise_en | fall_en)) == '0);

    // R7: an event needs a difference between level and history
    p_evt_needs_change_r7: assert property (@(posedge clk) disable iff (rst)
        armed |-> (evt & ~$past(cur ^ prev)) == '0);

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int unsigned PINS = DEF_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] rise_en,
    input  logic [PINS-1:0] fall_en,
    output logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pin_prev,
    output logic [PINS-1:0] evt
);

    logic [PINS-1:0] sync_lvl;
    logic [PINS-1:0] hist_lvl;
    logic            armed;

    gpio_sync_chain #(.PINS(PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (sync_lvl)
    );

    gpio_sample_hist #(.PINS(PINS), .STAGES(SYNC_DEPTH)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .cur   (sync_lvl),
        .prev  (hist_lvl),
        .armed (armed)
    );

    gpio_edge_match #(.PINS(PINS)) u_match (
        .clk     (clk),
        .rst     (rst),
        .armed   (armed),
        .cur     (sync_lvl),
        .prev    (hist_lvl),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .evt     (evt)
    );

    assign pin_level = sync_lvl;
    assign pin_prev  = hist_lvl;

    // R9: silence while not armed
    p_warmup_silent_r9: assert property (@(posedge clk) disable iff (rst)
        !armed |-> evt == '0);

    // R1: two-clock synchronizer latency, checked once fully armed
    p_sync_lag_r1: assert property (@(posedge clk) disable iff (rst)
        armed |-> pin_level == $past(pin_in, 2));

    // R8: event register cleared by reset
    p_evt_clear_r8: assert property (@(posedge clk) $past(rst) |-> evt == '0);

endmodule

// File: tb/tb_gpio_edge_detect.sv
module tb_gpio_edge_detect;

    localparam int W      = 32;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pin_in  = '1;
    logic [W-1:0] rise_en = '1;
    logic [W-1:0] fall_en = '0;
    logic [W-1:0] pin_level, pin_prev, evt;

    gpio_edge_detect #(.PINS(W)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .rise_en(rise_en),
        .fall_en(fall_en), .pin_level(pin_level), .pin_prev(pin_prev), .evt(evt)
    );

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        int           cyc;
        logic [W-1:0] vec;
        string        req;
    } exp_t;

    exp_t         sb_q[$];
    int           cyc = 0;
    int           n_chk = 0;
    int           n_bad = 0;
    logic [W-1:0] cur = '1;
    bit           done = 0;

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every cycle, evt must match the queued item or be zero
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sb_q.size() != 0 && sb_q[0].cyc == cyc) begin
                chk(evt, sb_q[0].vec, sb_q[0].req);
                void'(sb_q.pop_front());
            end else begin
                chk(evt, '0, "R7 no unexpected event");
            end
        end
    end

    // Driver: compute expected events from the selects, push, apply
    task automatic drive(input logic [W-1:0] v, input string req);
        logic [W-1:0] e;
        e = (v & ~cur & rise_en) | (~v & cur & fall_en);
        if (e != '0) sb_q.push_back('{cyc: cyc + 3, vec: e, req: req});
        pin_in = v;
        cur    = v;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        chk(pin_level, '0, "R8 level in reset");
        chk(pin_prev,  '0, "R8 prev in reset");
        chk(evt,       '0, "R8 evt in reset");
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        n_bad++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R8 + R9: pin high through reset, rising enabled everywhere
        do_reset();
        idle(6);
        chk(pin_level, '1, "R9 pin high at release, level");
        chk(evt, '0, "R9 no false edge after release");

        // R1 + R2: latency of level and history
        rise_en = '0; fall_en = '0;
        pin_in = 32'h0000_0000; cur = '0;
        @(negedge clk);
        chk(pin_level, '1, "R1 level unchanged after one edge");
        @(negedge clk);
        chk(pin_level, '0, "R1 level after two edges");
        chk(pin_prev,  '1, "R2 prev still old");
        @(negedge clk);
        chk(pin_prev,  '0, "R2 prev after three edges");
        idle(3);

        // R3: rising only
        rise_en = '1; fall_en = '0;
        drive(32'h0000_00F0, "R3 rising event");
        idle(2);
        drive(32'h0000_0000, "R3 falling ignored");
        idle(4);
        drive(32'h8000_0001, "R3 rising end bits");
        idle(4);

        // R4: falling only
        rise_en = '0; fall_en = '1;
        drive(32'h8000_0000, "R4 falling event");
        idle(4);
        drive(32'hFFFF_0000, "R4 rising ignored");
        idle(4);
        drive(32'h0F0F_0000, "R4 falling pattern");
        idle(4);

        // R5: both edges, back-to-back toggles give one pulse per edge
        rise_en = '1; fall_en = '1;
        drive(32'hF0F0_00FF, "R5 any edge");
        drive(32'h0F0F_FF00, "R5 any edge back-to-back");
        drive(32'h0F0F_FF00, "R5 hold");
        drive(32'h0000_0000, "R5 any edge fall");
        idle(4);

        // R6: nothing selected
        rise_en = '0; fall_en = '0;
        drive(32'hFFFF_FFFF, "R6 no selects");
        drive(32'h0000_0000, "R6 no selects");
        idle(5);

        // R11 / R7: mixed per-pin selects
        rise_en = 32'h5555_5555; fall_en = 32'hAAAA_AAAA;
        drive(32'hFFFF_FFFF, "R11 per-pin rise on even bits");
        idle(1);
        drive(32'h0000_0000, "R11 per-pin fall on odd bits");
        idle(1);
        drive(32'h1234_5678, "R7 mixed pattern");
        drive(32'h8765_4321, "R7 mixed pattern");
        idle(5);

        // R10: glitch between two edges
        rise_en = '1; fall_en = '1;
        pin_in = cur ^ 32'h00FF_FF00;
        #(PERIOD/5);
        pin_in = cur;
        idle(5);
        chk(pin_level, cur, "R10 glitch not seen in level");

        // R8: reset mid-run with pins high
        drive(32'hFFFF_FFFF, "R5 before reset");
        idle(5);
        do_reset();
        idle(6);
        chk(pin_level, '1, "R9 level after second reset");
        chk(evt, '0, "R9 quiet after second reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule